// File: doc/BRIEF.md
# Paged Host Register and Memory Window

This block sits between an 8-bit microprocessor bus and a time-slot switching core. It decodes an 8-bit host address and either reaches a small bank of configuration registers or a 32-location window into one of two 512-entry memories. One memory holds switched traffic samples, filled by the core. The other holds per-channel connection words, written by the host and read by the core.

The window is paged. Four bits of the control register pick one of 16 streams, and a fifth bit picks which memory the window shows. The five low address bits then pick one of 32 channels inside that stream. The selected location is stream × 32 + channel, which is the same indexing the core uses on its own ports. Host reads are registered: the data appears in the cycle after the read strobe, and it stays there until the next read.

Top module: `host_page_access`

## Requirements
- R1: While rst_ni is low, every configuration output (ctrl_o, mode_o, align_o, offset_o) and host_rdata_o is zero.
- R2: A host read presents its data on host_rdata_o in the cycle after host_rd_i is sampled high. host_rdata_o keeps that value until the next read.
- R3: With address bit 7 clear, only addresses 0x00 to 0x06 are registers. A read of any address from 0x07 to 0x7F returns zero. A write to any of those addresses changes no register.
- R4: With address bit 7 set, the location is ctrl[3:0] × 32 + addr[4:0]. Address bits 6:5 are ignored, so 0xA0 to 0xFF alias 0x80 to 0x9F. Control bits 7:5 have no effect on the page.
- R5: ctrl bit 4 = 1 routes window accesses to the connection memory. ctrl bit 4 = 0 routes them to the data memory.
- R6: Host writes into the window while it shows the data memory are ignored. A later read of that location returns the value the core stored.
- R7: A host write into the connection memory is visible on core_cm_rdata_o one cycle after core_cm_addr_i addresses that location. The core read port reads every cycle.
- R8: A core write (core_dm_we_i) to data memory location L is returned by a later host read of the window mapped onto L.
- R9: Reads in a cycle that also writes the same location return the old value. This applies to a host read against a core data-memory write, to a core connection-memory read against a host write, and to a register read against a write of that register.
- R10: The registers are control 0x00 (ctrl_o), interface mode 0x01 (mode_o), frame alignment 0x02 (align_o), and frame offsets 0x03 to 0x06 (offset_o bytes 0 to 3, byte i in bits 8i+7:8i). A write takes effect on the output in the next cycle, and reads return the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_addr_i | input | 8 | Host address |
| host_wdata_i | input | 8 | Host write data |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | 8 | Host read data, one cycle after the read |
| core_dm_we_i | input | 1 | Core write into data memory |
| core_dm_addr_i | input | 9 | Core data-memory location |
| core_dm_wdata_i | input | 8 | Core data-memory write data |
| core_cm_addr_i | input | 9 | Core connection-memory read location |
| core_cm_rdata_o | output | 8 | Connection word, one cycle after its address |
| ctrl_o | output | 8 | Control register |
| mode_o | output | 8 | Interface mode register |
| align_o | output | 8 | Frame alignment register |
| offset_o | output | 32 | Four frame offset registers |

## Verification
Two accesses can meet on one memory location in the same cycle. One case is a host read of the data window while the core writes that location. The other is a host write to the connection window while the core read port addresses that location. The bench sets up both cases on purpose and expects the pre-write value in the first cycle and the new value in the next. The same rule is checked for a register read paired with a write of that register.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int ADDR_W     = 8;
  localparam int NUM_OFFSET = 4;
  localparam int REG_CTRL   = 0;
  localparam int REG_MODE   = 1;
  localparam int REG_ALIGN  = 2;
  localparam int REG_OFS0   = 3;
  localparam int NUM_REGS   = REG_OFS0 + NUM_OFFSET;
  localparam int MEM_SEL_BIT = 4;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_DM   = 2'd2,
    TGT_CM   = 2'd3
  } tgt_e;
endpackage

// File: rtl/hpa_decode.sv
module hpa_decode
  import hpa_pkg::*;
#(
  parameter int DW  = 8,
  parameter int CHW = 5,
  parameter int STW = 4,
  localparam int LW = STW + CHW
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     ctrl_i,
  output tgt_e              tgt_o,
  output logic [ADDR_W-2:0] reg_idx_o,
  output logic [LW-1:0]     loc_o
);
  always_comb begin
    if (addr_i[ADDR_W-1]) tgt_o = ctrl_i[MEM_SEL_BIT] ? TGT_CM : TGT_DM;
    else                  tgt_o = TGT_REG;
  end

  assign reg_idx_o = addr_i[ADDR_W-2:0];
  // stream from page bits, channel from low address bits
  assign loc_o = {ctrl_i[STW-1:0], addr_i[CHW-1:0]};
endmodule

// File: rtl/hpa_regs.sv
module hpa_regs
  import hpa_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [ADDR_W-2:0]      idx_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic [DW-1:0]          ctrl_o,
  output logic [DW-1:0]          mode_o,
  output logic [DW-1:0]          align_o,
  output logic [NUM_OFFSET*DW-1:0] offset_o
);
  logic [DW-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  regs_q[r] <= '0;
      else if (wr_i && idx_i == (ADDR_W-1)'(r))     regs_q[r] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (idx_i == (ADDR_W-1)'(r)) rdata_o = regs_q[r];
  end

  assign ctrl_o  = regs_q[REG_CTRL];
  assign mode_o  = regs_q[REG_MODE];
  assign align_o = regs_q[REG_ALIGN];
  for (genvar i = 0; i < NUM_OFFSET; i++) begin : g_ofs
    assign offset_o[i*DW +: DW] = regs_q[REG_OFS0+i];
  end
endmodule

// File: rtl/hpa_ram.sv
module hpa_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 512,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_re_i,
  input  logic          a_we_i,
  input  logic [LW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_re_i,
  input  logic          b_we_i,
  input  logic [LW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (a_we_i) mem[a_addr_i] <= a_wdata_i;
    if (b_we_i) mem[b_addr_i] <= b_wdata_i;
  end

  // read-before-write on both ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_re_i) a_rdata_o <= mem[a_addr_i];
      if (b_re_i) b_rdata_o <= mem[b_addr_i];
    end
  end
endmodule

// File: rtl/host_page_access.sv
module host_page_access
  import hpa_pkg::*;
#(
  parameter int DW          = 8,
  parameter int NUM_STREAMS = 16,
  parameter int CH_PER_ST   = 32,
  localparam int STW        = $clog2(NUM_STREAMS),
  localparam int CHW        = $clog2(CH_PER_ST),
  localparam int LW         = STW + CHW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        host_addr_i,
  input  logic [DW-1:0]            host_wdata_i,
  input  logic                     host_wr_i,
  input  logic                     host_rd_i,
  output logic [DW-1:0]            host_rdata_o,
  input  logic                     core_dm_we_i,
  input  logic [LW-1:0]            core_dm_addr_i,
  input  logic [DW-1:0]            core_dm_wdata_i,
  input  logic [LW-1:0]            core_cm_addr_i,
  output logic [DW-1:0]            core_cm_rdata_o,
  output logic [DW-1:0]            ctrl_o,
  output logic [DW-1:0]            mode_o,
  output logic [DW-1:0]            align_o,
  output logic [NUM_OFFSET*DW-1:0] offset_o
);
  localparam int NUM_MEM = 2;  // 0: data memory, 1: connection memory

  tgt_e              tgt;
  tgt_e              rsel_q;
  logic [ADDR_W-2:0] reg_idx;
  logic [LW-1:0]     loc;
  logic [DW-1:0]     reg_rdata, reg_rd_q;

  hpa_decode #(.DW(DW), .CHW(CHW), .STW(STW)) u_dec (
    .addr_i    (host_addr_i),
    .ctrl_i    (ctrl_o),
    .tgt_o     (tgt),
    .reg_idx_o (reg_idx),
    .loc_o     (loc)
  );

  hpa_regs #(.DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (host_wr_i && tgt == TGT_REG),
    .idx_i    (reg_idx),
    .wdata_i  (host_wdata_i),
    .rdata_o  (reg_rdata),
    .ctrl_o   (ctrl_o),
    .mode_o   (mode_o),
    .align_o  (align_o),
    .offset_o (offset_o)
  );

  logic [DW-1:0] host_mem_rd [NUM_MEM];
  logic [DW-1:0] core_mem_rd [NUM_MEM];

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    localparam bit IS_CM = (m == 1);
    localparam tgt_e MY_TGT = IS_CM ? TGT_CM : TGT_DM;
    hpa_ram #(.DW(DW), .DEPTH(NUM_STREAMS*CH_PER_ST)) u_ram (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .a_re_i    (host_rd_i && tgt == MY_TGT),
      .a_we_i    (IS_CM && host_wr_i && tgt == MY_TGT),  // data memory: host writes dropped
      .a_addr_i  (loc),
      .a_wdata_i (host_wdata_i),
      .a_rdata_o (host_mem_rd[m]),
      .b_re_i    (IS_CM),
      .b_we_i    (!IS_CM && core_dm_we_i),
      .b_addr_i  (IS_CM ? core_cm_addr_i : core_dm_addr_i),
      .b_wdata_i (core_dm_wdata_i),
      .b_rdata_o (core_mem_rd[m])
    );
  end

  assign core_cm_rdata_o = core_mem_rd[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_q   <= TGT_NONE;
      reg_rd_q <= '0;
    end else if (host_rd_i) begin
      rsel_q <= tgt;
      if (tgt == TGT_REG) reg_rd_q <= reg_rdata;
    end
  end

  always_comb begin
    unique case (rsel_q)
      TGT_REG: host_rdata_o = reg_rd_q;
      TGT_DM:  host_rdata_o = host_mem_rd[0];
      TGT_CM:  host_rdata_o = host_mem_rd[1];
      default: host_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/hpa_checker.sv
module hpa_checker
  import hpa_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 9
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [ADDR_W-1:0]        host_addr_i,
  input logic [DW-1:0]            host_wdata_i,
  input logic                     host_wr_i,
  input logic                     host_rd_i,
  input logic [DW-1:0]            host_rdata_o,
  input logic [DW-1:0]            ctrl_o,
  input logic [DW-1:0]            mode_o,
  input logic [DW-1:0]            align_o,
  input logic [NUM_OFFSET*DW-1:0] offset_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (ctrl_o == '0 && mode_o == '0 && align_o == '0 && offset_o == '0 && host_rdata_o == '0));

  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> $stable(host_rdata_o));

  // R3
  unassigned_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !host_addr_i[ADDR_W-1] && host_addr_i[ADDR_W-2:0] >= (ADDR_W-1)'(NUM_REGS))
    |=> host_rdata_o == '0);

  // R10
  ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == ADDR_W'(REG_CTRL)) |=> ctrl_o == $past(host_wdata_i));

  // R3
  ctrl_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_wr_i && host_addr_i == ADDR_W'(REG_CTRL)) |=> $stable(ctrl_o));

  // R10
  mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && host_addr_i == ADDR_W'(REG_MODE)) |=> mode_o == $past(host_wdata_i));

  // R3
  align_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_wr_i && host_addr_i == ADDR_W'(REG_ALIGN)) |=> $stable(align_o));
endmodule

bind host_page_access hpa_checker #(.DW(DW), .LW(LW)) u_chk (.*);

// File: tb/host_page_access_tb.sv
module host_page_access_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0, host_wdata = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        core_dm_we = 1'b0;
  logic [8:0]  core_dm_addr = '0, core_cm_addr = '0;
  logic [7:0]  core_dm_wdata = '0;
  logic [7:0]  core_cm_rdata, ctrl, mode, align;
  logic [31:0] offset;

  host_page_access u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_wr_i(host_wr), .host_rd_i(host_rd), .host_rdata_o(host_rdata),
    .core_dm_we_i(core_dm_we), .core_dm_addr_i(core_dm_addr), .core_dm_wdata_i(core_dm_wdata),
    .core_cm_addr_i(core_cm_addr), .core_cm_rdata_o(core_cm_rdata),
    .ctrl_o(ctrl), .mode_o(mode), .align_o(align), .offset_o(offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: -1 marks an unknown value
  int dm_m [512];
  int cm_m [512];
  int regs_m [7];
  int exp_rd, exp_core;
  int checks = 0, errors = 0;
  string tag = "R1";

  initial begin
    foreach (dm_m[i]) dm_m[i] = -1;
    foreach (cm_m[i]) cm_m[i] = -1;
    foreach (regs_m[i]) regs_m[i] = 0;
    exp_rd = 0;
    exp_core = 0;
  end

  always @(posedge clk) begin
    int a, loc;
    a = int'(host_addr);
    if (!rst_n) begin
      foreach (regs_m[i]) regs_m[i] = 0;
      exp_rd = 0;
      exp_core = 0;
    end else begin
      loc = (regs_m[0] % 16) * 32 + (a % 32);
      exp_core = cm_m[core_cm_addr];
      if (host_rd) begin
        if (a >= 128) exp_rd = ((regs_m[0] / 16) % 2 == 1) ? cm_m[loc] : dm_m[loc];
        else          exp_rd = (a < 7) ? regs_m[a] : 0;
      end
      if (host_wr) begin
        if (a >= 128) begin
          if ((regs_m[0] / 16) % 2 == 1) cm_m[loc] = int'(host_wdata);
        end else if (a < 7) regs_m[a] = int'(host_wdata);
      end
      if (core_dm_we) dm_m[core_dm_addr] = int'(core_dm_wdata);
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    check("ctrl_o", int'(ctrl), regs_m[0]);
    check("mode_o", int'(mode), regs_m[1]);
    check("align_o", int'(align), regs_m[2]);
    for (int i = 0; i < 4; i++) check("offset_o", int'(offset[i*8 +: 8]), regs_m[3+i]);
    if (exp_rd >= 0)   check("host_rdata_o", int'(host_rdata), exp_rd);
    if (exp_core >= 0) check("core_cm_rdata_o", int'(core_cm_rdata), exp_core);
  end

  task automatic drive(input bit rd, input bit wr, input int a, input int d,
                       input bit dwe = 0, input int dloc = 0, input int dd = 0);
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = 8'(a); host_wdata = 8'(d);
    core_dm_we = dwe; core_dm_addr = 9'(dloc); core_dm_wdata = 8'(dd);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    drive(1, 0, 8'h00, 0); idle();

    tag = "R10";
    for (int r = 0; r < 7; r++) drive(0, 1, r, 8'h21 + r * 8'h13);
    for (int r = 0; r < 7; r++) drive(1, 0, r, 0);
    idle();

    tag = "R2";
    drive(1, 0, 8'h01, 0); idle(); idle(); idle();

    tag = "R3";
    drive(0, 1, 8'h07, 8'hAA); drive(0, 1, 8'h40, 8'h55); drive(0, 1, 8'h7F, 8'hFF);
    drive(1, 0, 8'h07, 0); drive(1, 0, 8'h7F, 0); drive(1, 0, 8'h02, 0);
    idle();

    tag = "R5";
    foreach (int_list_dummy[k]) ;
    for (int s = 0; s < 16; s += 5) begin
      drive(0, 1, 8'h00, 8'h10 | s);
      drive(0, 1, 8'h80, 8'h30 + s);
      drive(0, 1, 8'h81, 8'h50 + s);
      drive(0, 1, 8'h9F, 8'h70 + s);
      drive(1, 0, 8'h80, 0); drive(1, 0, 8'h81, 0); drive(1, 0, 8'h9F, 0);
    end
    idle();

    tag = "R7";
    for (int s = 0; s < 16; s += 5) begin
      @(negedge clk); core_cm_addr = 9'(s * 32 + 31);
      idle();
    end
    idle();

    tag = "R4";
    drive(0, 1, 8'h00, 8'h15);
    drive(0, 1, 8'hE3, 8'h9C);
    drive(1, 0, 8'h83, 0);
    drive(1, 0, 8'hC3, 0);
    @(negedge clk); core_cm_addr = 9'(5 * 32 + 3);
    idle(); idle();

    tag = "R8";
    for (int c = 0; c < 32; c += 7) drive(0, 0, 0, 0, 1, 2 * 32 + c, 8'hC0 + c);
    drive(0, 1, 8'h00, 8'hE2);  // bit 4 clear, bits 7:5 set: stream 2 data memory
    for (int c = 0; c < 32; c += 7) drive(1, 0, 8'h80 + c, 0);
    idle();

    tag = "R6";
    drive(0, 1, 8'h87, 8'h0F);
    drive(1, 0, 8'h87, 0);
    idle();

    tag = "R9";
    drive(0, 1, 8'h00, 8'h03);
    drive(0, 0, 0, 0, 1, 3 * 32 + 7, 8'h11);
    drive(1, 0, 8'h87, 0, 1, 3 * 32 + 7, 8'h22);
    drive(1, 0, 8'h87, 0);
    drive(0, 1, 8'h00, 8'h13);
    drive(0, 1, 8'h87, 8'h33);
    @(negedge clk); core_cm_addr = 9'(3 * 32 + 7);
    host_wr = 1'b0; host_rd = 1'b0;
    drive(0, 1, 8'h87, 8'h44);
    idle();
    drive(1, 1, 8'h02, 8'h66);
    drive(1, 0, 8'h02, 0);
    idle(); idle();

    summary();
    $finish;
  end

  int int_list_dummy [1];
endmodule